// File: doc/BRIEF.md
# Burst DMA Transfer Sequencer

A single-channel copy engine that moves words from a source region to a destination region over a plain memory bus. The caller presents a control word, two start addresses and a word count, then raises a request. The engine copies either one word at a time (a read immediately followed by its write) or four words at a time: four reads fill a small holding buffer, then four writes drain it in the same order.

The transfer runs in one of two ways. In demand mode, each request pulse moves one burst and the engine then waits for the next pulse. The addresses and the remaining count are kept between pulses, so the copy carries on where it stopped. In block mode, the first request launches every burst of the transfer. The engine ignores any later pulses. Between bursts it can leave a programmable number of idle cycles on the bus. An acknowledge output is high whenever the engine is moving data. A done flag rises when the count has run out.

Top module: `burst_dma`

## Requirements
- R1: After reset, `dack`, `done` and `mem_req` are all low.
- R2: With `ctrl[3:1]` not equal to 3'b001 (demand mode), each request moves one burst and then returns to idle. In one-word mode (`ctrl[4]` and `ctrl[5]` not both 1), a burst is one read at source address N and, in the next cycle, one write of that word to destination address N.
- R3: With `ctrl[4]` and `ctrl[5]` both 1, a burst is four reads at consecutive source addresses followed by four writes at consecutive destination addresses. The words are written in the order they were read.
- R4: The remaining count drops by one per one-word burst and by four per four-word burst, and saturates at zero. A four-word burst started with fewer than four words left still moves four words and ends the transfer.
- R5: With `ctrl[3:1]` equal to 3'b001 (block mode), one request pulse runs bursts until the count is exhausted. Extra request pulses during the transfer do not change the number or order of accesses.
- R6: In block mode, `ctrl[16:13]` gives the number of cycles with no bus access between the last write of one burst and the first read of the next. A value of zero makes the bursts back to back.
- R7: The source and destination addresses each step by one after every access. They are kept across bursts, so in demand mode the next request continues at the following word.
- R8: `dack` is high in every cycle of a burst, including block-mode gaps. `done` rises as the transfer ends, is never high together with `dack`, and clears when the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 17 | Control word: mode at [3:1], burst size at [5:4], gap at [16:13] |
| src_base | input | 16 | First source word address, taken when a transfer starts |
| dst_base | input | 16 | First destination word address, taken when a transfer starts |
| xfer_cnt | input | 16 | Number of words to copy, taken when a transfer starts |
| dreq | input | 1 | Transfer request |
| dack | output | 1 | High while a burst is in progress |
| done | output | 1 | Transfer finished |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the read |

## Verification
The bench records every bus access with its cycle number and compares the trace with the expected read and write order. A design that interleaved the four-word bursts, or wrote the buffer out of order, would fail those comparisons at the first write. In block mode the bench sends extra request pulses and a count that is not a multiple of four. A design that honoured the extra pulses, or that wrapped the count below zero, would make the wrong number of accesses. The gap test measures the cycle distance between bursts, which exposes an off-by-one in the idle timer. Demand-mode tests check that a second request continues at the next addresses instead of starting again from the base.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_t;

  localparam logic [2:0] MODE_BLOCK = 3'b001;
  localparam int         BURST_MAX  = 4;
endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode #(
  parameter int CTRL_W = 17,
  parameter int GAP_W  = 4
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic              is_block,
  output logic              is_burst4,
  output logic [GAP_W-1:0]  gap
);
  import dma_pkg::*;

  always_comb begin
    is_block  = (ctrl[3:1] == MODE_BLOCK);
    is_burst4 = ctrl[4] & ctrl[5];
    gap       = ctrl[13 +: GAP_W];
  end
endmodule

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [GAP_W-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (load)                     tmr_d = load_val;
    else if (run && tmr_q != '0)  tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expire = (tmr_q <= GAP_W'(1));
endmodule

// File: rtl/burst_dma.sv
module burst_dma #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int CW     = 16,
  parameter int CTRL_W = 17,
  parameter int GAP_W  = 4,
  localparam int BN    = dma_pkg::BURST_MAX,
  localparam int IW    = $clog2(BN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic [CW-1:0]     xfer_cnt,
  input  logic              dreq,
  output logic              dack,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  import dma_pkg::*;

  logic             dec_block, dec_burst4;
  logic [GAP_W-1:0] dec_gap;

  dma_ctrl_decode #(.CTRL_W(CTRL_W), .GAP_W(GAP_W)) u_dec (
    .ctrl(ctrl), .is_block(dec_block), .is_burst4(dec_burst4), .gap(dec_gap)
  );

  dma_state_t       st_q, st_d;
  logic [AW-1:0]    src_q, src_d, dst_q, dst_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             act_q, act_d, done_q, done_d;
  logic             blk_q, blk_d, b4_q, b4_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             last_beat, gap_load, gap_expire;
  logic [CW-1:0]    beats, cnt_after;
  logic [DW-1:0]    buf_rd;

  dma_hold_buf #(.DW(DW), .DEPTH(BN)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_q == ST_RD), .wr_idx(idx_q), .wr_data(mem_rdata),
    .rd_idx(idx_q), .rd_data(buf_rd)
  );

  dma_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(gap_load), .load_val(gap_q), .run(st_q == ST_GAP),
    .expire(gap_expire)
  );

  assign beats     = b4_q ? CW'(BN) : CW'(1);
  assign last_beat = b4_q ? (idx_q == IW'(BN-1)) : 1'b1;
  assign cnt_after = (cnt_q > beats) ? (cnt_q - beats) : '0;

  always_comb begin
    st_d = st_q; src_d = src_q; dst_d = dst_q; cnt_d = cnt_q; idx_d = idx_q;
    act_d = act_q; done_d = done_q; blk_d = blk_q; b4_d = b4_q; gap_d = gap_q;
    gap_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (dreq) begin
          st_d   = ST_RD;
          idx_d  = '0;
          done_d = 1'b0;
          if (!act_q) begin
            act_d = 1'b1;
            src_d = src_base;
            dst_d = dst_base;
            cnt_d = xfer_cnt;
            blk_d = dec_block;
            b4_d  = dec_burst4;
            gap_d = dec_gap;
          end
        end
      end
      ST_RD: begin
        src_d = src_q + 1'b1;
        if (last_beat) begin
          st_d  = ST_WR;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WR: begin
        dst_d = dst_q + 1'b1;
        if (last_beat) begin
          idx_d = '0;
          cnt_d = cnt_after;
          if (cnt_after == '0) begin
            st_d   = ST_IDLE;
            act_d  = 1'b0;
            done_d = 1'b1;
          end else if (!blk_q) begin
            st_d = ST_IDLE;
          end else if (gap_q != '0) begin
            st_d     = ST_GAP;
            gap_load = 1'b1;
          end else begin
            st_d = ST_RD;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_expire) st_d = ST_RD;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; src_q <= '0; dst_q <= '0; cnt_q <= '0; idx_q <= '0;
      act_q <= 1'b0; done_q <= 1'b0; blk_q <= 1'b0; b4_q <= 1'b0; gap_q <= '0;
    end else begin
      st_q <= st_d; src_q <= src_d; dst_q <= dst_d; cnt_q <= cnt_d; idx_q <= idx_d;
      act_q <= act_d; done_q <= done_d; blk_q <= blk_d; b4_q <= b4_d; gap_q <= gap_d;
    end
  end

  assign dack      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = buf_rd;

  // R8: the done flag and the acknowledge are never high together
  a_r8_done_not_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dack);

  // R2: in one-word mode every read is followed by a write in the next cycle
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !b4_q) |=> (mem_req && mem_we));

  // R7: a read followed by another read steps the address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_we || !mem_req || mem_addr == $past(mem_addr) + 1'b1));

  // R6: no bus access while the gap timer runs
  a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (!mem_req && dack));

  // R4: during a transfer the remaining count never increases
  a_r4_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: tb/burst_dma_tb.sv
module burst_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 64;

  logic        clk, rst_n, dreq;
  logic [16:0] ctrl;
  logic [15:0] src_base, dst_base, xfer_cnt;
  logic        dack, done, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  burst_dma u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .src_base(src_base), .dst_base(dst_base),
    .xfer_cnt(xfer_cnt), .dreq(dreq), .dack(dack), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [MEMW];
  int          log_addr [512];
  bit          log_we [512];
  int          log_cyc [512];
  int          n_log, cyc;
  int          checks, errors;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      log_addr[n_log] <= int'(mem_addr);
      log_we[n_log]   <= mem_we;
      log_cyc[n_log]  <= cyc;
      n_log           <= n_log + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) dreq = 1'b1;
    @(negedge clk) dreq = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && dack; i++) @(negedge clk);
  endtask

  task automatic check_log(input int base, input int k, input bit we, input int addr, input string tag);
    check(log_we[base+k] == we && log_addr[base+k] == addr, tag, log_addr[base+k], addr);
  endtask

  task automatic t_reset();
    check(!dack && !done && !mem_req, "R1 reset outputs", {dack, done, mem_req}, 0);
  endtask

  task automatic t_single();
    int b;
    ctrl = 17'h0; src_base = 16'd0; dst_base = 16'd32; xfer_cnt = 16'd3;
    b = n_log;
    pulse_req();
    check(dack == 1'b1, "R8 dack during burst", dack, 1);
    wait_idle();
    check(n_log - b == 2, "R2 one burst two accesses", n_log - b, 2);
    check_log(b, 0, 1'b0, 0, "R2 read addr 0");
    check_log(b, 1, 1'b1, 32, "R2 write addr 32");
    check(log_cyc[b+1] == log_cyc[b] + 1, "R2 write next cycle", log_cyc[b+1], log_cyc[b] + 1);
    check(done == 1'b0, "R4 not done after 1 of 3", done, 0);
    pulse_req(); wait_idle();
    check_log(b, 2, 1'b0, 1, "R7 continue src 1");
    check_log(b, 3, 1'b1, 33, "R7 continue dst 33");
    pulse_req(); wait_idle();
    check(done == 1'b1, "R4 done after third burst", done, 1);
    check(mem[34] == mem[2], "R2 data copied", int'(mem[34]), int'(mem[2]));
  endtask

  task automatic t_four();
    int b;
    ctrl = 17'h30; src_base = 16'd8; dst_base = 16'd40; xfer_cnt = 16'd8;
    b = n_log;
    pulse_req();
    check(done == 1'b0, "R8 done cleared at start", done, 0);
    wait_idle();
    check(n_log - b == 8, "R3 eight accesses", n_log - b, 8);
    for (int k = 0; k < 4; k++) check_log(b, k, 1'b0, 8 + k, "R3 read order");
    for (int k = 0; k < 4; k++) check_log(b, 4 + k, 1'b1, 40 + k, "R3 write order");
    for (int k = 0; k < 4; k++)
      check(mem[40+k] == mem[8+k], "R3 data order", int'(mem[40+k]), int'(mem[8+k]));
    check(done == 1'b0, "R4 minus four not done", done, 0);
    pulse_req(); wait_idle();
    check_log(b, 8, 1'b0, 12, "R7 four-burst continues");
    check(done == 1'b1, "R4 done after second four", done, 1);
  endtask

  task automatic t_block_gap();
    int b;
    ctrl = 17'h0; ctrl[3:1] = 3'b001; ctrl[5:4] = 2'b11; ctrl[16:13] = 4'd3;
    src_base = 16'd16; dst_base = 16'd48; xfer_cnt = 16'd6;
    b = n_log;
    pulse_req();
    repeat (3) pulse_req();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && !dack, "R5 block runs to done", done, 1);
    check(n_log - b == 16, "R4 R5 saturated count gives two bursts", n_log - b, 16);
    check_log(b, 8, 1'b0, 20, "R5 second burst src");
    check_log(b, 15, 1'b1, 55, "R5 last write dst");
    check(log_cyc[b+8] - log_cyc[b+7] == 4, "R6 gap of three idle cycles",
          log_cyc[b+8] - log_cyc[b+7], 4);
    check(mem[55] == mem[23], "R3 block data", int'(mem[55]), int'(mem[23]));
  endtask

  task automatic t_block_single();
    int b;
    ctrl = 17'h0; ctrl[3:1] = 3'b001;
    src_base = 16'd4; dst_base = 16'd60; xfer_cnt = 16'd3;
    b = n_log;
    pulse_req();
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    check(n_log - b == 6, "R5 one pulse three words", n_log - b, 6);
    check(log_cyc[b+2] - log_cyc[b+1] == 1, "R6 zero gap back to back",
          log_cyc[b+2] - log_cyc[b+1], 1);
    check_log(b, 5, 1'b1, 62, "R7 block dst step");
  endtask

  initial begin
    checks = 0; errors = 0; n_log = 0; cyc = 0;
    for (int i = 0; i < MEMW; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
    rst_n = 1'b0; dreq = 1'b0; ctrl = '0;
    src_base = '0; dst_base = '0; xfer_cnt = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_four();
    t_block_gap();
    t_block_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule